// File: doc/BRIEF.md
# Capture/Reload Timer with Edge Detect

This block is a 16-bit timer/counter with a companion 16-bit hold register. The hold register acts as a capture register or as a reload value, depending on the operating mode. The count advances on one of two sources:

- a prescaled tick taken from the system clock, either every 2 or every 32 clocks;
- qualified transitions on an external input pin.

The pin first passes through a synchronizer. A programmable detector then turns each qualified transition into a single-cycle pulse.

Software reaches every register through a byte-wide register port. Writes are synchronous and reads are combinational. The block raises an overflow flag and an external-event flag, and it drives a one-cycle baud tick for a serial transmitter or receiver.

The block uses a four-state mode machine:

- **ST_IDLE**: the run bit is clear and nothing counts.
- **ST_CAPTURE**: rollover sets the overflow flag, and qualified pin transitions can snapshot the count.
- **ST_RELOAD**: overflow or a qualified transition reloads the count from the hold register.
- **ST_BAUD**: overflow reloads the count and clocks a divide-by-16 stage instead of setting the flag.

Every transition happens on a write to the control register, as decoded from the written value:

- **GO_IDLE**: run bit cleared.
- **GO_BAUD**: run bit set with either the receive-clock or the transmit-clock select bit set.
- **GO_RELOAD**: run bit set with the reload-mode bit set and neither clock select bit set.
- **GO_CAPTURE**: run bit set and none of the other mode bits set.

Register map (addr): 0 count low, 1 count high, 2 hold low, 3 hold high, 4 control, 5 edge select, 6 flags.

Control bits:

| Bit | Meaning |
|-----|---------|
| 0 | run |
| 1 | count pin transitions (1) or prescaled ticks (0) |
| 2 | reload mode |
| 3 | external enable |
| 4 | receive-clock select |
| 5 | transmit-clock select |
| 6 | slow prescale (divide by 32 when 1, by 2 when 0) |

Flags register: bit 0 is the overflow flag and bit 1 is the external flag.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, the count, hold and control registers read 0, the flags read 0, `baud_tick` is 0, and the edge-select field reads 2 (falling edge).
- R2: With control bit 1 clear and the run bit set, the count advances by one every 2 clocks when bit 6 is 0 and every 32 clocks when bit 6 is 1. With the run bit clear, the count does not change.
- R3: With control bit 1 set, the count advances once per qualified pin transition. Edge-select value 0 qualifies no transition, 1 qualifies rising, 2 qualifies falling, and 3 qualifies both.
- R4: The pin is synchronized through two flops. A qualified transition affects the count on the third rising clock edge after the pin changes.
- R5: In capture mode, an advance from 0xFFFF wraps the count to 0 and sets the overflow flag.
- R6: In capture mode with external enable set, a qualified transition copies the pre-advance count into the hold register and sets the external flag. Counting continues.
- R7: In reload mode, an overflow loads the count from the hold register and sets the overflow flag.
- R8: In reload mode with external enable set, a qualified transition loads the count from the hold register and sets the external flag. The reload takes precedence over the advance.
- R9: With either clock-select bit set, an overflow reloads the count from the hold register and leaves the overflow flag unchanged. Every 16th overflow produces a `baud_tick` pulse one clock long.
- R10: Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R11: A write to a count byte sets that byte to the written value in that cycle. The other byte keeps its value, and that cycle's advance, reload and overflow are suppressed.
- R12: With external enable clear, qualified transitions neither change the hold register nor set the external flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data (combinational) |
| ext_pin | input | 1 | Asynchronous external event input |
| ovf_flag | output | 1 | Overflow flag |
| ext_flag | output | 1 | External-event flag |
| baud_tick | output | 1 | One-cycle pulse every 16 overflows in baud mode |

## Verification
The assertions check the following on every cycle:

- A count-byte write overrides that cycle's update and holds the other byte.
- A capture-mode rollover clears the count and sets the overflow flag.
- No rising edge of the overflow flag follows a baud-mode cycle.
- The external flag wins over a simultaneous clear.
- Prescaler and baud pulses last one cycle, and the count stays still in transition-counting mode when no pulse arrives.

The bench scenarios cover what no single-cycle property can show:

- the exact prescale rates;
- the count of qualified transitions for each edge-select value;
- the captured values across a series of events;
- the reload values;
- the one-in-sixteen baud tick rate over a long window.

// File: rtl/crt_pkg.sv
package crt_pkg;
    localparam int unsigned ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO  = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI  = 3'd1;
    localparam logic [ADDR_W-1:0] A_HOLD_LO = 3'd2;
    localparam logic [ADDR_W-1:0] A_HOLD_HI = 3'd3;
    localparam logic [ADDR_W-1:0] A_CTL     = 3'd4;
    localparam logic [ADDR_W-1:0] A_EDGE    = 3'd5;
    localparam logic [ADDR_W-1:0] A_FLAGS   = 3'd6;

    localparam int unsigned C_RUN     = 0;
    localparam int unsigned C_EXT_SRC = 1;
    localparam int unsigned C_RELOAD  = 2;
    localparam int unsigned C_EXT_EN  = 3;
    localparam int unsigned C_RX      = 4;
    localparam int unsigned C_TX      = 5;
    localparam int unsigned C_SLOW    = 6;

    localparam int unsigned F_OVF = 0;
    localparam int unsigned F_EXF = 1;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CAPTURE = 2'd1,
        ST_RELOAD  = 2'd2,
        ST_BAUD    = 2'd3
    } tmr_state_t;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'd0,
        EDGE_RISE = 2'd1,
        EDGE_FALL = 2'd2,
        EDGE_BOTH = 2'd3
    } edge_sel_t;

    function automatic tmr_state_t decode_mode(input logic [7:0] ctl);
        tmr_state_t s;
        if (!ctl[C_RUN])
            s = ST_IDLE;                       // GO_IDLE
        else if (ctl[C_RX] || ctl[C_TX])
            s = ST_BAUD;                       // GO_BAUD
        else if (ctl[C_RELOAD])
            s = ST_RELOAD;                     // GO_RELOAD
        else
            s = ST_CAPTURE;                    // GO_CAPTURE
        return s;
    endfunction
endpackage

// File: rtl/crt_edge_qual.sv
module crt_edge_qual
    import crt_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_t sel,
    output logic      pulse
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= cur;
    end

    always_comb begin
        unique case (sel)
            EDGE_NONE: pulse = 1'b0;
            EDGE_RISE: pulse = cur & ~prev_q;
            EDGE_FALL: pulse = ~cur & prev_q;
            EDGE_BOTH: pulse = cur ^ prev_q;
            default:   pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/crt_prescaler.sv
module crt_prescaler #(
    parameter int unsigned FAST_DIV = 2,
    parameter int unsigned SLOW_DIV = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic slow,
    output logic tick
);
    localparam int unsigned PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PW-1:0] FAST_LIM = PW'(FAST_DIV - 1);
    localparam logic [PW-1:0] SLOW_LIM = PW'(SLOW_DIV - 1);

    logic [PW-1:0] div_q;
    logic [PW-1:0] limit;

    assign limit = slow ? SLOW_LIM : FAST_LIM;
    assign tick  = run && (div_q >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       div_q <= '0;
        else if (!run)    div_q <= '0;
        else if (tick)    div_q <= '0;
        else              div_q <= div_q + 1'b1;
    end

    // R2
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/crt_baud_div.sv
module crt_baud_div #(
    parameter int unsigned RATIO = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ovf_evt,
    output logic tick
);
    localparam int unsigned BW = (RATIO > 1) ? $clog2(RATIO) : 1;
    localparam logic [BW-1:0] LAST = BW'(RATIO - 1);

    logic [BW-1:0] ev_q;
    logic          tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q   <= '0;
            tick_q <= 1'b0;
        end else if (!active) begin
            ev_q   <= '0;
            tick_q <= 1'b0;
        end else if (ovf_evt) begin
            if (ev_q == LAST) begin
                ev_q   <= '0;
                tick_q <= 1'b1;
            end else begin
                ev_q   <= ev_q + 1'b1;
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // R9
    baud_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_q |=> !tick_q);
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import crt_pkg::*;
#(
    parameter int unsigned FAST_DIV    = 2,
    parameter int unsigned SLOW_DIV    = 32,
    parameter int unsigned BAUD_RATIO  = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ext_pin,
    output logic       ovf_flag,
    output logic       ext_flag,
    output logic       baud_tick
);
    localparam int unsigned CW = 16;
    localparam logic [CW-1:0] CNT_MAX = '1;

    tmr_state_t    state_q;
    logic [6:0]    ctl_q;
    edge_sel_t     edge_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] hold_q;
    logic          ovf_q;
    logic          exf_q;

    logic wr_cnt_lo, wr_cnt_hi, wr_hold_lo, wr_hold_hi;
    logic wr_ctl, wr_edge, wr_flags, cnt_wr;
    logic edge_pulse, pre_tick;
    logic count_step, ovf_evt, ext_evt;

    logic [CW-1:0] cnt_nx;
    logic          cap_load;
    logic          ovf_set;
    logic          exf_set;
    logic          baud_ovf;

    assign wr_cnt_lo  = wr_en && (addr == A_CNT_LO);
    assign wr_cnt_hi  = wr_en && (addr == A_CNT_HI);
    assign wr_hold_lo = wr_en && (addr == A_HOLD_LO);
    assign wr_hold_hi = wr_en && (addr == A_HOLD_HI);
    assign wr_ctl     = wr_en && (addr == A_CTL);
    assign wr_edge    = wr_en && (addr == A_EDGE);
    assign wr_flags   = wr_en && (addr == A_FLAGS);
    assign cnt_wr     = wr_cnt_lo || wr_cnt_hi;

    crt_edge_qual #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (ext_pin),
        .sel   (edge_q),
        .pulse (edge_pulse)
    );

    crt_prescaler #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .run   ((state_q != ST_IDLE) && !ctl_q[C_EXT_SRC]),
        .slow  (ctl_q[C_SLOW]),
        .tick  (pre_tick)
    );

    crt_baud_div #(.RATIO(BAUD_RATIO)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (state_q == ST_BAUD),
        .ovf_evt (baud_ovf),
        .tick    (baud_tick)
    );

    assign count_step = (state_q != ST_IDLE) &&
                        (ctl_q[C_EXT_SRC] ? edge_pulse : pre_tick);
    assign ovf_evt    = count_step && (cnt_q == CNT_MAX) && !cnt_wr;
    assign ext_evt    = edge_pulse && ctl_q[C_EXT_EN] && (state_q != ST_IDLE);

    // State register: mode changes only on a control write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state_q <= ST_IDLE;
        else if (wr_ctl) state_q <= decode_mode(wdata);
    end

    // Per-state actions.
    always_comb begin
        cnt_nx   = cnt_q;
        cap_load = 1'b0;
        ovf_set  = 1'b0;
        exf_set  = 1'b0;
        baud_ovf = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_nx = cnt_q;
            end
            ST_CAPTURE: begin
                cnt_nx   = count_step ? cnt_q + 1'b1 : cnt_q;
                ovf_set  = ovf_evt;
                cap_load = ext_evt;
                exf_set  = ext_evt;
            end
            ST_RELOAD: begin
                if (ovf_evt || ext_evt) cnt_nx = hold_q;
                else if (count_step)    cnt_nx = cnt_q + 1'b1;
                ovf_set = ovf_evt;
                exf_set = ext_evt;
            end
            ST_BAUD: begin
                if (ovf_evt || ext_evt) cnt_nx = hold_q;
                else if (count_step)    cnt_nx = cnt_q + 1'b1;
                baud_ovf = ovf_evt;
                exf_set  = ext_evt;
            end
            default: cnt_nx = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt_q <= '0;
        else if (wr_cnt_lo) cnt_q[7:0]  <= wdata;
        else if (wr_cnt_hi) cnt_q[15:8] <= wdata;
        else                cnt_q <= cnt_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          hold_q <= '0;
        else if (cap_load)   hold_q <= cnt_q;
        else if (wr_hold_lo) hold_q[7:0]  <= wdata;
        else if (wr_hold_hi) hold_q[15:8] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            edge_q <= EDGE_FALL;
        end else begin
            if (wr_ctl)  ctl_q  <= wdata[6:0];
            if (wr_edge) edge_q <= edge_sel_t'(wdata[1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            exf_q <= 1'b0;
        end else begin
            if (ovf_set)                        ovf_q <= 1'b1;
            else if (wr_flags && !wdata[F_OVF]) ovf_q <= 1'b0;
            if (exf_set)                        exf_q <= 1'b1;
            else if (wr_flags && !wdata[F_EXF]) exf_q <= 1'b0;
        end
    end

    always_comb begin
        case (addr)
            A_CNT_LO:  rdata = cnt_q[7:0];
            A_CNT_HI:  rdata = cnt_q[15:8];
            A_HOLD_LO: rdata = hold_q[7:0];
            A_HOLD_HI: rdata = hold_q[15:8];
            A_CTL:     rdata = {1'b0, ctl_q};
            A_EDGE:    rdata = {6'b0, edge_q};
            A_FLAGS:   rdata = {6'b0, exf_q, ovf_q};
            default:   rdata = 8'h00;
        endcase
    end

    assign ovf_flag = ovf_q;
    assign ext_flag = exf_q;

    // R11
    cnt_lo_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_lo |=> (cnt_q[7:0] == $past(wdata)) && (cnt_q[15:8] == $past(cnt_q[15:8])));

    // R11
    cnt_hi_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt_hi |=> (cnt_q[15:8] == $past(wdata)) && (cnt_q[7:0] == $past(cnt_q[7:0])));

    // R5
    capture_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && count_step && cnt_q == CNT_MAX && !cnt_wr)
        |=> (cnt_q == '0) && ovf_q);

    // R9
    baud_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BAUD) |=> !$rose(ovf_q));

    // R10
    exf_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flags && !wdata[F_EXF] && ext_evt) |=> exf_q);

    // R3
    pin_count_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CAPTURE && ctl_q[C_EXT_SRC] && !edge_pulse && !cnt_wr)
        |=> $stable(cnt_q));
endmodule

// File: tb/cap_reload_timer_bench.sv
`timescale 1ns/1ps
module cap_reload_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ext_pin = 1'b0;
    logic       ovf_flag, ext_flag, baud_tick;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cap_reload_timer u_cap_reload_timer (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .ext_pin(ext_pin), .ovf_flag(ovf_flag),
        .ext_flag(ext_flag), .baud_tick(baud_tick)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] d);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 3'd1, hi);
        d = {hi, lo};
    endtask

    task automatic set_cnt(input logic [15:0] v);
        wr(3'd0, v[7:0]);
        wr(3'd1, v[15:8]);
    endtask

    task automatic set_hold(input logic [15:0] v);
        wr(3'd2, v[7:0]);
        wr(3'd3, v[15:8]);
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        ext_pin = v;
    endtask

    task automatic pin_settle(input logic v);
        set_pin(v);
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [15:0] w;
        int          ticks;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd16(3'd0, w); chk("R1 count", w, 16'h0000);
        rd16(3'd2, w); chk("R1 hold", w, 16'h0000);
        rd(3'd4, b);   chk("R1 ctl", {8'h0, b}, 16'h0000);
        rd(3'd5, b);   chk("R1 edge sel", {8'h0, b}, 16'h0002);
        rd(3'd6, b);   chk("R1 flags", {8'h0, b}, 16'h0000);
        chk("R1 baud_tick", {15'h0, baud_tick}, 16'h0000);

        // R2 prescaled timing, fast and slow
        wr(3'd4, 8'h01);
        repeat (9) @(negedge clk);
        wr(3'd4, 8'h00);
        rd16(3'd0, w); chk("R2 div2 five ticks", w, 16'd5);
        set_cnt(16'h0000);
        wr(3'd4, 8'h41);
        repeat (95) @(negedge clk);
        wr(3'd4, 8'h00);
        rd16(3'd0, w); chk("R2 div32 three ticks", w, 16'd3);
        repeat (50) @(negedge clk);
        rd16(3'd0, w); chk("R2 stopped holds", w, 16'd3);

        // R3/R4/R12 edge-select sweep, counting pin transitions, ext enable off
        for (int s = 0; s < 4; s++) begin
            int exp_n;
            wr(3'd5, 8'(s));
            set_cnt(16'h0000);
            wr(3'd4, 8'h03);
            for (int k = 0; k < 6; k++) pin_settle(~ext_pin);
            wr(3'd4, 8'h00);
            exp_n = (s == 0) ? 0 : (s == 3) ? 6 : 3;
            rd16(3'd0, w); chk($sformatf("R3 edge sel %0d count", s), w, 16'(exp_n));
            rd16(3'd2, w); chk("R12 hold untouched", w, 16'h0000);
            chk("R12 ext flag clear", {15'h0, ext_flag}, 16'h0000);
        end

        // R6 capture with external enable, both edges
        wr(3'd5, 8'h03);
        set_cnt(16'h1230);
        wr(3'd4, 8'h0B);
        for (int k = 0; k < 3; k++) begin
            pin_settle(~ext_pin);
            rd16(3'd2, w); chk("R6 captured value", w, 16'h1230 + 16'(k));
            rd16(3'd0, w); chk("R6 count continues", w, 16'h1231 + 16'(k));
        end
        chk("R6 ext flag set", {15'h0, ext_flag}, 16'h0001);
        wr(3'd4, 8'h00);

        // R10 clear with 0, write 1 no effect
        wr(3'd6, 8'h00);
        chk("R10 cleared", {15'h0, ext_flag}, 16'h0000);
        wr(3'd6, 8'hFF);
        rd(3'd6, b); chk("R10 write 1 no effect", {8'h0, b}, 16'h0000);

        // R5 capture overflow
        set_cnt(16'hFFFF);
        wr(3'd4, 8'h03);
        pin_settle(~ext_pin);
        wr(3'd4, 8'h00);
        rd16(3'd0, w); chk("R5 wrap to zero", w, 16'h0000);
        chk("R5 overflow flag", {15'h0, ovf_flag}, 16'h0001);

        // R7 reload on overflow
        wr(3'd6, 8'h00);
        set_hold(16'h1234);
        set_cnt(16'hFFFF);
        wr(3'd4, 8'h07);
        pin_settle(~ext_pin);
        wr(3'd4, 8'h00);
        rd16(3'd0, w); chk("R7 reloaded", w, 16'h1234);
        chk("R7 overflow flag", {15'h0, ovf_flag}, 16'h0001);
        chk("R7 ext flag clear", {15'h0, ext_flag}, 16'h0000);

        // R8 reload on external transition
        wr(3'd6, 8'h00);
        set_cnt(16'h0010);
        wr(3'd4, 8'h0F);
        pin_settle(~ext_pin);
        wr(3'd4, 8'h00);
        rd16(3'd0, w); chk("R8 forced reload", w, 16'h1234);
        chk("R8 ext flag", {15'h0, ext_flag}, 16'h0001);
        chk("R8 no overflow flag", {15'h0, ovf_flag}, 16'h0000);
        wr(3'd6, 8'h00);

        // R11 count write beats same-cycle increment (R4 timing: third edge)
        set_cnt(16'h00FF);
        wr(3'd4, 8'h03);
        set_pin(~ext_pin);
        @(negedge clk);
        wr(3'd0, 8'h55);
        repeat (4) @(negedge clk);
        wr(3'd4, 8'h00);
        rd16(3'd0, w); chk("R11 write overrides step", w, 16'h0055);

        // R10 hardware set wins over clear (same R4 alignment)
        wr(3'd4, 8'h0B);
        set_pin(~ext_pin);
        @(negedge clk);
        wr(3'd6, 8'h00);
        repeat (4) @(negedge clk);
        wr(3'd4, 8'h00);
        chk("R10 set beats clear", {15'h0, ext_flag}, 16'h0001);
        wr(3'd6, 8'h00);

        // R9 baud mode, receive select then transmit select
        set_hold(16'hFFFF);
        set_cnt(16'hFFFF);
        wr(3'd4, 8'h11);
        ticks = 0;
        for (int c = 0; c < 320; c++) begin
            @(negedge clk);
            if (baud_tick) ticks++;
        end
        wr(3'd4, 8'h00);
        chk("R9 rx baud ticks", 16'(ticks), 16'd10);
        chk("R9 no overflow flag", {15'h0, ovf_flag}, 16'h0000);
        rd16(3'd0, w); chk("R9 count reloaded", w, 16'hFFFF);
        wr(3'd4, 8'h21);
        ticks = 0;
        for (int c = 0; c < 160; c++) begin
            @(negedge clk);
            if (baud_tick) ticks++;
        end
        wr(3'd4, 8'h00);
        chk("R9 tx baud ticks", 16'(ticks), 16'd5);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule